// File: doc/BRIEF.md
# Flash Status Pin Mode Controller

This block drives the active-low status pin of a flash memory controller from events raised by its internal write state machine. After reset the pin is a level ready/busy indicator. It is low while the state machine works, and high when the state machine is ready or suspended. A configuration command with an 8-bit code can switch the pin into an interrupt role. In that role the pin rests high and drops low for a fixed time when a selected kind of operation completes.

Two bits of the code pick the events that cause a pulse. Bit 0 selects erase completion and bit 1 selects program completion. Code 0x00 restores the level indicator. The block accepts a code only while the state machine is neither busy nor suspended and the code is well formed. Any rejected command sets two sticky error flags, which represent status-register bits 4 and 5, and leaves the current mode as it was. The pulse width is a parameter given in clock cycles. The default of 63 cycles is about 250 ns at 250 MHz.

The external reset pin is `rst_n`. It asserts asynchronously and is released to the logic through a two-stage synchronizer.

Top module: `flash_sts_ctrl`

## Requirements
- R1: While reset is held and after it is released, the block is in level mode with both error flags clear. The reset release reaches the logic two clock edges after `rst_n` rises.
- R2: In level mode (code 0x00) `sts_n_o` equals the inverse of `busy_i` in the same cycle. `susp_i` has no effect on it.
- R3: An accepted code selects the pulse sources. Bit 0 = 1 enables a pulse on `erase_done_i` and bit 1 = 1 enables a pulse on `prog_done_i`. A strobe whose bit is 0 leaves the pin unchanged.
- R4: An accepted code 0x00 returns the pin to level mode from the cycle after the command.
- R5: An enabled strobe sampled at a clock edge drives `sts_n_o` low for exactly PULSE_CYCLES cycles, starting right after that edge.
- R6: An enabled strobe that arrives during a pulse reloads the timer, so the pin stays low for PULSE_CYCLES cycles counted from the later strobe.
- R7: A configuration command sampled while `busy_i` or `susp_i` is high is rejected. It leaves the mode unchanged and sets both error flags.
- R8: A code with any of bits 7..2 set is invalid. It is rejected, leaves the mode unchanged and sets both error flags.
- R9: The error flags stay set until `clr_err_i` is sampled. If a rejection and a clear arrive in the same cycle, the flags are set.
- R10: In a pulse mode the pin is high whenever no pulse is in progress, whatever the value of `busy_i`.
- R11: A mode stays until another command is accepted or reset is applied. An accepted command ends any pulse in progress, and in that cycle the command takes precedence over a strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset pin, asynchronous assertion |
| busy_i | input | 1 | Write state machine is busy |
| susp_i | input | 1 | Write state machine is suspended |
| erase_done_i | input | 1 | One-cycle strobe: an erase finished |
| prog_done_i | input | 1 | One-cycle strobe: a program finished |
| cfg_wr_i | input | 1 | Configuration command strobe |
| cfg_code_i | input | 8 | Configuration code carried with the command |
| clr_err_i | input | 1 | Clears the error flags |
| sts_n_o | output | 1 | Active-low status pin |
| err_o | output | 2 | Error flags: [0] is status bit 4, [1] is status bit 5 |

## Verification
The bench targets three groups of cases.

A pulse re-armed partway through its run must be stretched to a full PULSE_CYCLES from the later strobe. A design that ignores the second strobe releases the pin early. A design that counts from the first strobe has the wrong low time.

Commands that arrive while the state machine is busy or suspended, or that carry high code bits, must leave the mode alone. A design that stores them changes which strobes cause pulses, and its missing error flags show at the port. A rejection that coincides with a clear is another such case.

An accepted code 0x00 in the middle of a pulse, and a reset applied in a pulse mode, must both return the pin to following `busy_i`. A design that keeps the stale counter or mode leaves the pin low, or high, while the state machine is busy.

// File: rtl/stsp_pkg.sv
package stsp_pkg;
  localparam int unsigned CODE_W = 8;
  localparam int unsigned NUM_EVT = 2;

  typedef enum logic [1:0] {
    MODE_LEVEL = 2'b00,
    MODE_ERASE = 2'b01,
    MODE_PROG  = 2'b10,
    MODE_BOTH  = 2'b11
  } sts_mode_e;
endpackage

// File: rtl/stsp_cfg_ctrl.sv
module stsp_cfg_ctrl
  import stsp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy_i,
  input  logic              susp_i,
  input  logic              cfg_wr_i,
  input  logic [CODE_W-1:0] cfg_code_i,
  input  logic              clr_err_i,
  output sts_mode_e         mode_o,
  output logic              take_o,
  output logic [1:0]        err_o
);
  localparam int unsigned SEL_W = 2;

  sts_mode_e  mode_q, mode_d;
  logic       mode_en;
  logic [1:0] err_q, err_d;
  logic       err_en;
  logic       code_ok, idle, take, reject;

  always_comb begin
    code_ok = (cfg_code_i[CODE_W-1:SEL_W] == '0);
    idle    = ~busy_i & ~susp_i;
    take    = cfg_wr_i & idle & code_ok;
    reject  = cfg_wr_i & ~take;
    mode_en = take;
    mode_d  = sts_mode_e'(cfg_code_i[SEL_W-1:0]);
    err_en  = reject | clr_err_i;
    err_d   = reject ? 2'b11 : 2'b00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_LEVEL;
    end else if (mode_en) begin
      mode_q <= mode_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= 2'b00;
    end else if (err_en) begin
      err_q <= err_d;
    end
  end

  assign mode_o = mode_q;
  assign take_o = take;
  assign err_o  = err_q;
endmodule

// File: rtl/stsp_pulse_gen.sv
module stsp_pulse_gen #(
  parameter int unsigned PULSE_CYCLES = 63
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_i,
  input  logic cancel_i,
  output logic active_o
);
  localparam int unsigned CNT_W = $clog2(PULSE_CYCLES + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(PULSE_CYCLES);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = cancel_i | trig_i | (cnt_q != '0);
    if (cancel_i) begin
      cnt_d = '0;
    end else if (trig_i) begin
      cnt_d = LOAD;
    end else begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign active_o = (cnt_q != '0);
endmodule

// File: rtl/stsp_pin_drive.sv
module stsp_pin_drive
  import stsp_pkg::*;
(
  input  sts_mode_e          mode_i,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic               busy_i,
  input  logic               pulse_active_i,
  output logic               hit_o,
  output logic               sts_n_o
);
  logic [NUM_EVT-1:0] evt_hit;

  for (genvar g = 0; g < NUM_EVT; g++) begin : g_evt
    assign evt_hit[g] = evt_i[g] & mode_i[g];
  end

  assign hit_o   = |evt_hit;
  assign sts_n_o = (mode_i == MODE_LEVEL) ? ~busy_i : ~pulse_active_i;
endmodule

// File: rtl/flash_sts_ctrl.sv
module flash_sts_ctrl
  import stsp_pkg::*;
#(
  parameter int unsigned PULSE_CYCLES = 63
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy_i,
  input  logic              susp_i,
  input  logic              erase_done_i,
  input  logic              prog_done_i,
  input  logic              cfg_wr_i,
  input  logic [CODE_W-1:0] cfg_code_i,
  input  logic              clr_err_i,
  output logic              sts_n_o,
  output logic [1:0]        err_o
);
  logic [1:0] rst_sync_q;
  logic       rst_core_n;
  sts_mode_e  mode_w;
  logic       cfg_take;
  logic       evt_hit;
  logic       pulse_active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_core_n = rst_sync_q[1];

  stsp_cfg_ctrl u_cfg (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .busy_i     (busy_i),
    .susp_i     (susp_i),
    .cfg_wr_i   (cfg_wr_i),
    .cfg_code_i (cfg_code_i),
    .clr_err_i  (clr_err_i),
    .mode_o     (mode_w),
    .take_o     (cfg_take),
    .err_o      (err_o)
  );

  stsp_pulse_gen #(.PULSE_CYCLES(PULSE_CYCLES)) u_pulse (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .trig_i   (evt_hit),
    .cancel_i (cfg_take),
    .active_o (pulse_active)
  );

  stsp_pin_drive u_pin (
    .mode_i         (mode_w),
    .evt_i          ({prog_done_i, erase_done_i}),
    .busy_i         (busy_i),
    .pulse_active_i (pulse_active),
    .hit_o          (evt_hit),
    .sts_n_o        (sts_n_o)
  );
endmodule

// File: rtl/flash_sts_ctrl_chk.sv
module flash_sts_ctrl_chk
  import stsp_pkg::*;
(
  input logic              clk,
  input logic              rst_core_n,
  input logic              busy_i,
  input logic              susp_i,
  input logic              erase_done_i,
  input logic              prog_done_i,
  input logic              cfg_wr_i,
  input logic [CODE_W-1:0] cfg_code_i,
  input logic              clr_err_i,
  input logic              sts_n_o,
  input logic [1:0]        err_o,
  input sts_mode_e         mode_w,
  input logic              pulse_active
);
  AST_LEVEL_TRACKS_BUSY: assert property (@(posedge clk) disable iff (!rst_core_n)
    (mode_w == MODE_LEVEL) |-> (sts_n_o == !busy_i)); // R2
  AST_PULSE_STARTS: assert property (@(posedge clk) disable iff (!rst_core_n)
    (!cfg_wr_i && ((mode_w[0] && erase_done_i) || (mode_w[1] && prog_done_i))) |=> !sts_n_o); // R5
  AST_BUSY_REJECT_FLAGS: assert property (@(posedge clk) disable iff (!rst_core_n)
    (cfg_wr_i && (busy_i || susp_i)) |=> (err_o == 2'b11)); // R7
  AST_BUSY_REJECT_KEEPS_MODE: assert property (@(posedge clk) disable iff (!rst_core_n)
    (cfg_wr_i && (busy_i || susp_i)) |=> $stable(mode_w)); // R7
  AST_BAD_CODE_FLAGS: assert property (@(posedge clk) disable iff (!rst_core_n)
    (cfg_wr_i && (cfg_code_i[CODE_W-1:2] != '0)) |=> (err_o == 2'b11 && $stable(mode_w))); // R8
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_core_n)
    (err_o == 2'b11 && !clr_err_i) |=> (err_o == 2'b11)); // R9
  AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (!rst_core_n)
    (clr_err_i && !cfg_wr_i) |=> (err_o == 2'b00)); // R9
  AST_PULSE_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_core_n)
    (mode_w != MODE_LEVEL && !pulse_active) |-> sts_n_o); // R10
  AST_MODE_HOLDS: assert property (@(posedge clk) disable iff (!rst_core_n)
    !cfg_wr_i |=> $stable(mode_w)); // R11
endmodule

bind flash_sts_ctrl flash_sts_ctrl_chk u_chk (
  .clk          (clk),
  .rst_core_n   (rst_core_n),
  .busy_i       (busy_i),
  .susp_i       (susp_i),
  .erase_done_i (erase_done_i),
  .prog_done_i  (prog_done_i),
  .cfg_wr_i     (cfg_wr_i),
  .cfg_code_i   (cfg_code_i),
  .clr_err_i    (clr_err_i),
  .sts_n_o      (sts_n_o),
  .err_o        (err_o),
  .mode_w       (mode_w),
  .pulse_active (pulse_active)
);

// File: tb/flash_sts_ctrl_tb.sv
`timescale 1ns/1ps
module flash_sts_ctrl_tb;
  localparam int P = 63;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       busy_i, susp_i, erase_done_i, prog_done_i, cfg_wr_i, clr_err_i;
  logic [7:0] cfg_code_i;
  logic       sts_n_o;
  logic [1:0] err_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // reference model state
  logic [1:0] m_mode;
  int         m_cnt;
  logic       m_err;

  always #2 clk = ~clk;

  flash_sts_ctrl #(.PULSE_CYCLES(P)) u_dut (
    .clk(clk), .rst_n(rst_n), .busy_i(busy_i), .susp_i(susp_i),
    .erase_done_i(erase_done_i), .prog_done_i(prog_done_i),
    .cfg_wr_i(cfg_wr_i), .cfg_code_i(cfg_code_i), .clr_err_i(clr_err_i),
    .sts_n_o(sts_n_o), .err_o(err_o)
  );

  function automatic logic exp_sts(input logic [1:0] md, input int cnt, input logic busy);
    return (md == 2'b00) ? !busy : (cnt == 0);
  endfunction

  function automatic logic cfg_accept(input logic wr, input logic busy, input logic susp,
                                      input logic [7:0] code);
    return wr && !busy && !susp && (code[7:2] == 6'd0);
  endfunction

  task automatic model_step();
    logic acc;
    acc = cfg_accept(cfg_wr_i, busy_i, susp_i, cfg_code_i);
    if (acc) begin
      m_mode = cfg_code_i[1:0];
      m_cnt  = 0;
    end else if ((erase_done_i && m_mode[0]) || (prog_done_i && m_mode[1])) begin
      m_cnt = P;
    end else if (m_cnt != 0) begin
      m_cnt = m_cnt - 1;
    end
    if (cfg_wr_i && !acc) m_err = 1'b1;
    else if (clr_err_i) m_err = 1'b0;
  endtask

  task automatic check(input string tag, input logic [1:0] got, input logic [1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0b expected %0b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic cyc(input string tag, input logic b, input logic s, input logic ed,
                     input logic pd, input logic wr, input logic [7:0] code, input logic clr);
    @(negedge clk);
    busy_i = b; susp_i = s; erase_done_i = ed; prog_done_i = pd;
    cfg_wr_i = wr; cfg_code_i = code; clr_err_i = clr;
    #1;
    check({tag, " pin"}, {1'b0, sts_n_o}, {1'b0, exp_sts(m_mode, m_cnt, b)});
    check({tag, " err"}, err_o, {m_err, m_err});
    @(posedge clk);
    model_step();
  endtask

  task automatic idle(input string tag, input int n, input logic b);
    for (int i = 0; i < n; i++) cyc(tag, b, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    busy_i = 0; susp_i = 0; erase_done_i = 0; prog_done_i = 0;
    cfg_wr_i = 0; cfg_code_i = 0; clr_err_i = 0;
    m_mode = 2'b00; m_cnt = 0; m_err = 1'b0;
    #1;
    check("R1 in reset pin", {1'b0, sts_n_o}, 2'b01);
    check("R1 in reset err", err_o, 2'b00);
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    idle("R1", 3, 1'b0);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b1;
    do_reset();
    idle("R1", 2, 1'b0);
    idle("R2", 3, 1'b1);
    cyc("R2", 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0);
    // erase-only mode
    cyc("R3", 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h01, 1'b0);
    cyc("R3", 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0);
    idle("R3", 3, 1'b0);
    cyc("R5", 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0);
    idle("R5", P + 3, 1'b0);
    idle("R10", 5, 1'b1);
    // retrigger
    cyc("R6", 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0);
    idle("R6", 30, 1'b0);
    cyc("R6", 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0);
    idle("R6", P + 3, 1'b0);
    // invalid code keeps erase mode
    cyc("R8", 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h06, 1'b0);
    cyc("R8", 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0);
    cyc("R8", 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0);
    idle("R8", P + 2, 1'b0);
    // sticky errors, set beats clear
    idle("R9", 3, 1'b0);
    cyc("R9", 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h80, 1'b1);
    idle("R9", 2, 1'b0);
    cyc("R9", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1);
    idle("R9", 2, 1'b0);
    // rejected while busy / suspended
    cyc("R7", 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'h02, 1'b0);
    cyc("R7", 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 1'b1);
    cyc("R7", 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 8'h00, 1'b0);
    idle("R7", 2, 1'b1);
    cyc("R7", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1);
    // program-only mode, cancelled by code 0x00
    cyc("R3", 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h02, 1'b0);
    cyc("R3", 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0);
    idle("R3", 2, 1'b0);
    cyc("R3", 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0);
    idle("R11", 10, 1'b0);
    cyc("R11", 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 8'h00, 1'b0);
    idle("R4", 3, 1'b1);
    idle("R4", 2, 1'b0);
    // both events, then reset returns to level
    cyc("R3", 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h03, 1'b0);
    cyc("R3", 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0);
    idle("R11", 5, 1'b1);
    do_reset();
    idle("R11", 3, 1'b1);
    // constrained random
    for (int i = 0; i < 4000; i++) begin
      logic b, s, ed, pd, wr, clr;
      logic [7:0] code;
      b    = ($urandom % 6) == 0;
      s    = ($urandom % 12) == 0;
      ed   = ($urandom % 40) == 0;
      pd   = ($urandom % 40) == 0;
      wr   = ($urandom % 30) == 0;
      clr  = ($urandom % 50) == 0;
      code = (($urandom % 4) == 0) ? 8'($urandom) : 8'($urandom % 4);
      cyc((m_mode == 2'b00) ? "R2" : "R10", b, s, ed, pd, wr, code, clr);
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule